// File: doc/BRIEF.md
# Dual-Port RAM with Cross-Port Mailbox Interrupts

This block is a synchronous two-port static memory in which each port (left and right) has its own enable, write strobe, output enable, address, write data, read data and write-inhibit input, so both sides can read and write at the same time without waiting on each other. The two highest words of the memory double as mailboxes. Word `DEPTH-2` is the left side's inbox and word `DEPTH-1` is the right side's inbox.

When the right port writes the left inbox, the left port's active-low interrupt output goes low. The left port drops it again by reading its inbox. The right side works the same way with the other word. Both mailbox words keep their ordinary storage function, so the doorbell write can carry a message byte. An active-low write-inhibit input per port blocks that port's writes. A blocked write changes neither the memory nor any interrupt. Ports are plain strobed memory ports, not streams. They have no back-pressure, and every enabled access completes in the cycle it is presented.

The memory depth is a power-of-two parameter. Only the low `log2(DEPTH)` address bits select a word, and any upper address bits are ignored. At a depth of 32768, the mailboxes therefore sit at the top two addresses of the full 15-bit space.

Top module: `dpmb_mailbox_ram`

## Requirements
- R1: After reset both interrupt outputs (`l_irq_n`, `r_irq_n`) are 1 (inactive) and both read-data outputs are 0.
- R2: A read (`en`=1, `wr`=0, `oe`=1) presents the addressed word on that port's `rdata` one clock later. In any other cycle `rdata` holds its previous value. A read of a word written by the other port in the same cycle returns the old word.
- R3: A write (`en`=1, `wr`=1, `busy_n`=1) stores `wdata` at the word selected by the low `log2(DEPTH)` address bits. Higher address bits are ignored.
- R4: While a port's `busy_n` is 0, its writes are blocked. The stored word is unchanged and no interrupt is raised by that write.
- R5: An unblocked right-port write to word `DEPTH-2` drives `l_irq_n` to 0 on the next clock.
- R6: An unblocked left-port write to word `DEPTH-1` drives `r_irq_n` to 0 on the next clock.
- R7: A left access with `en`=1 and `oe`=1 to word `DEPTH-2` returns `l_irq_n` to 1 on the next clock, whatever the value of `wr`. The same holds for the right port, word `DEPTH-1` and `r_irq_n`.
- R8: When a set event and a clear event for the same interrupt fall in the same cycle, the interrupt ends up active (0).
- R9: Both mailbox words are ordinary storage. A byte written there reads back unchanged from either port.
- R10: An interrupt is unaffected by its own port writing its own inbox and by the other port reading that inbox.
- R11: The ports operate concurrently on different words. If both write the same word in one cycle, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_en | input | 1 | Left access enable |
| l_wr | input | 1 | Left write strobe (1 = write) |
| l_oe | input | 1 | Left output enable |
| l_busy_n | input | 1 | Left write inhibit, active low |
| l_addr | input | AW | Left address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_en | input | 1 | Right access enable |
| r_wr | input | 1 | Right write strobe (1 = write) |
| r_oe | input | 1 | Right output enable |
| r_busy_n | input | 1 | Right write inhibit, active low |
| r_addr | input | AW | Right address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds the block with `DEPTH`=16 and the default 15-bit address and 8-bit data. This small depth lets it write and read back every word from each side, and each sweep crosses both mailboxes along the way. With the full address width, addresses whose upper bits are non-zero, such as 0x7FFE, alias onto the mailbox words, so the ignored-bits rule and the top-of-space placement can be tested on a small array. Same-cycle set/clear and same-word write collisions are placed deliberately.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // Inbox word of a side: left owns DEPTH-2, right owns DEPTH-1.
  function automatic int unsigned inbox_word(input side_e s, input int unsigned depth);
    return depth - 2 + ((s == SIDE_RIGHT) ? 1 : 0);
  endfunction

endpackage

// File: rtl/dpmb_store.sv
module dpmb_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic          l_oe,
  input  logic          l_busy_n,
  input  logic [IW-1:0] l_idx,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic          r_oe,
  input  logic          r_busy_n,
  input  logic [IW-1:0] r_idx,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);

  logic [DW-1:0] mem [DEPTH];

  logic l_we, r_we, l_re, r_re;
  assign l_we = l_en && l_wr && l_busy_n;
  assign r_we = r_en && r_wr && r_busy_n;
  assign l_re = l_en && !l_wr && l_oe;
  assign r_re = r_en && !r_wr && r_oe;

  // Right first, left last: left prevails on a same-word collision.
  always_ff @(posedge clk) begin
    if (r_we) mem[r_idx] <= r_wdata;
    if (l_we) mem[l_idx] <= l_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_re) l_rdata <= mem[l_idx];
      if (r_re) r_rdata <= mem[r_idx];
    end
  end

  // R4: a blocked write leaves its word untouched
  a_r4_left_inhibit_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_wr && !l_busy_n && !(r_we && r_idx == l_idx))
      |=> mem[$past(l_idx)] == $past(mem[l_idx]));

  a_r4_right_inhibit_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_wr && !r_busy_n && !(l_we && l_idx == r_idx))
      |=> mem[$past(r_idx)] == $past(mem[r_idx]));

endmodule

// File: rtl/dpmb_doorbell.sv
module dpmb_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq_n
);

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_n <= 1'b1;
    else if (set_evt) irq_n <= 1'b0;
    else if (clr_evt) irq_n <= 1'b1;
  end

  // R8: a set in the same cycle as a clear still leaves the flag active
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> !irq_n);

  // R7: a lone clear releases the flag
  a_r7_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> irq_n);

  // R10: without an event of its own the flag does not move
  a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && !set_evt) |=> $stable(irq_n));

endmodule

// File: rtl/dpmb_mailbox_ram.sv
module dpmb_mailbox_ram
  import dpmb_pkg::*;
#(
  parameter int AW    = 15,
  parameter int DW    = 8,
  parameter int DEPTH = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic          l_oe,
  input  logic          l_busy_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq_n,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic          r_oe,
  input  logic          r_busy_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_irq_n
);

  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0] idx [2];
  logic [1:0]    en, wr, oe, bsy_n, set_evt, clr_evt, irq_n;

  assign idx[0] = l_addr[IW-1:0];
  assign idx[1] = r_addr[IW-1:0];
  assign en     = {r_en, l_en};
  assign wr     = {r_wr, l_wr};
  assign oe     = {r_oe, l_oe};
  assign bsy_n  = {r_busy_n, l_busy_n};

  dpmb_store #(.DW(DW), .DEPTH(DEPTH)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .l_en     (l_en),
    .l_wr     (l_wr),
    .l_oe     (l_oe),
    .l_busy_n (l_busy_n),
    .l_idx    (idx[0]),
    .l_wdata  (l_wdata),
    .l_rdata  (l_rdata),
    .r_en     (r_en),
    .r_wr     (r_wr),
    .r_oe     (r_oe),
    .r_busy_n (r_busy_n),
    .r_idx    (idx[1]),
    .r_wdata  (r_wdata),
    .r_rdata  (r_rdata)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int            PEER  = 1 - s;
    localparam logic [IW-1:0] INBOX = IW'(inbox_word(side_e'(s), DEPTH));

    // Peer writes my inbox: raise. I read (en+oe) my inbox: release.
    assign set_evt[s] = en[PEER] && wr[PEER] && bsy_n[PEER] && (idx[PEER] == INBOX);
    assign clr_evt[s] = en[s] && oe[s] && (idx[s] == INBOX);

    dpmb_doorbell i_bell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_evt[s]),
      .clr_evt (clr_evt[s]),
      .irq_n   (irq_n[s])
    );
  end

  assign l_irq_n = irq_n[0];
  assign r_irq_n = irq_n[1];

  // R4: an inhibited peer write to my inbox does not pull my interrupt low
  a_r4_inhibit_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_wr && !r_busy_n && l_irq_n && !(l_en && l_wr && l_busy_n && 0))
      |=> l_irq_n);

endmodule

// File: tb/test_dpmb_mailbox_ram.sv
`timescale 1ns/1ps
module test_dpmb_mailbox_ram;

  localparam int AW = 15, DW = 8, DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic l_en, l_wr, l_oe, l_busy_n, r_en, r_wr, r_oe, r_busy_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dpmb_mailbox_ram #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_dpmb_mailbox_ram (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_busy_n(l_busy_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_busy_n(r_busy_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  function automatic logic [7:0] pat_l(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] pat_r(input int a);
    return 8'(((a * 53 + 200) & 255) ^ 8'h5A);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic idle_all();
    l_en = 0; l_wr = 0; l_oe = 0; l_busy_n = 1; l_addr = '0; l_wdata = '0;
    r_en = 0; r_wr = 0; r_oe = 0; r_busy_n = 1; r_addr = '0; r_wdata = '0;
  endtask

  task automatic drv_l(input logic en, wr, oe, bn, input logic [AW-1:0] a, input logic [7:0] d);
    l_en = en; l_wr = wr; l_oe = oe; l_busy_n = bn; l_addr = a; l_wdata = d;
  endtask
  task automatic drv_r(input logic en, wr, oe, bn, input logic [AW-1:0] a, input logic [7:0] d);
    r_en = en; r_wr = wr; r_oe = oe; r_busy_n = bn; r_addr = a; r_wdata = d;
  endtask

  // Apply driven inputs on one rising edge, return at the following falling edge.
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    idle_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 l_irq_n reset", l_irq_n, 1);
    chk("R1 r_irq_n reset", r_irq_n, 1);
    chk("R1 l_rdata reset", l_rdata, 0);
    chk("R1 r_rdata reset", r_rdata, 0);

    // Left fills every word; crossing word 15 rings the right side.
    for (int a = 0; a < DEPTH; a++) begin drv_l(1, 1, 0, 1, AW'(a), pat_l(a)); cyc(); end
    chk("R6 left wrote word 15", r_irq_n, 0);
    chk("R10 left wrote own inbox 14", l_irq_n, 1);
    for (int a = 0; a < DEPTH; a++) begin
      drv_r(1, 0, 1, 1, AW'(a), 0); cyc();
      chk("R3 right reads left data", r_rdata, pat_l(a));
      if (a == DEPTH - 2) chk("R10 right read of word 14 keeps r_irq", r_irq_n, 0);
    end
    chk("R7 right read of word 15 clears", r_irq_n, 1);

    // Right fills every word; crossing word 14 rings the left side.
    for (int a = 0; a < DEPTH; a++) begin drv_r(1, 1, 0, 1, AW'(a), pat_r(a)); cyc(); end
    chk("R5 right wrote word 14", l_irq_n, 0);
    chk("R10 right wrote own inbox 15", r_irq_n, 1);
    for (int a = 0; a < DEPTH; a++) begin
      drv_l(1, 0, 1, 1, AW'(a), 0); cyc();
      chk("R2 left reads right data", l_rdata, pat_r(a));
      if (a == DEPTH - 3) chk("R5 l_irq still low", l_irq_n, 0);
    end
    chk("R7 left read of word 14 clears", l_irq_n, 1);

    drv_l(1, 0, 0, 1, 15'd3, 0); cyc();
    chk("R2 rdata holds without oe", l_rdata, pat_r(15));

    drv_r(1, 1, 0, 0, 15'd14, 8'hAA); cyc();
    chk("R4 inhibited write raises nothing", l_irq_n, 1);
    drv_l(1, 0, 1, 1, 15'd14, 0); cyc();
    chk("R4 inhibited write keeps word 14", l_rdata, pat_r(14));
    drv_l(1, 1, 0, 0, 15'd15, 8'h11); cyc();
    chk("R4 left inhibited keeps r_irq", r_irq_n, 1);
    drv_r(1, 0, 1, 1, 15'd15, 0); cyc();
    chk("R4 left inhibited keeps word 15", r_rdata, pat_r(15));

    drv_r(1, 1, 0, 1, 15'd14, 8'h3C); cyc();
    chk("R5 doorbell with message", l_irq_n, 0);
    drv_r(1, 0, 1, 1, 15'd14, 0); cyc();
    chk("R9 message readable by sender", r_rdata, 8'h3C);
    chk("R10 peer read keeps l_irq", l_irq_n, 0);
    drv_l(1, 1, 1, 1, 15'd14, 8'h5C); cyc();
    chk("R7 clear with wr=1", l_irq_n, 1);
    drv_l(1, 0, 1, 1, 15'd14, 0); cyc();
    chk("R9 mailbox word written by owner", l_rdata, 8'h5C);

    drv_r(1, 1, 0, 1, 15'd14, 8'h77); drv_l(1, 0, 1, 1, 15'd14, 0); cyc();
    chk("R8 set beats clear", l_irq_n, 0);
    chk("R2 same-cycle read returns old word", l_rdata, 8'h5C);
    drv_l(1, 0, 1, 1, 15'd14, 0); cyc();
    chk("R9 new message", l_rdata, 8'h77);
    chk("R7 cleared afterwards", l_irq_n, 1);

    drv_l(1, 1, 0, 1, 15'd2, 8'hA1); drv_r(1, 1, 0, 1, 15'd5, 8'hB2); cyc();
    drv_l(1, 0, 1, 1, 15'd5, 0); drv_r(1, 0, 1, 1, 15'd2, 0); cyc();
    chk("R11 concurrent left read", l_rdata, 8'hB2);
    chk("R11 concurrent right read", r_rdata, 8'hA1);
    drv_l(1, 1, 0, 1, 15'd7, 8'hC3); drv_r(1, 1, 0, 1, 15'd7, 8'hD4); cyc();
    drv_r(1, 0, 1, 1, 15'd7, 0); cyc();
    chk("R11 collision keeps left data", r_rdata, 8'hC3);

    drv_l(1, 1, 0, 1, 15'h0014, 8'hE5); cyc();
    drv_r(1, 0, 1, 1, 15'd4, 0); cyc();
    chk("R3 upper address bits ignored", r_rdata, 8'hE5);
    drv_r(1, 1, 0, 1, 15'h7FFE, 8'h99); cyc();
    chk("R5 top address aliases inbox", l_irq_n, 0);
    drv_l(1, 0, 1, 1, 15'h7FFE, 0); cyc();
    chk("R9 aliased message", l_rdata, 8'h99);
    chk("R7 aliased clear", l_irq_n, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule